// File: doc/BRIEF.md
# Constant-Rate Memory Request Shaper

This block sits between a load or DMA engine and a memory request port and hides how much a protected tenant actually uses memory. Each tenant has its own queue for real requests. For a tenant with shaping switched on, a per-tenant timer opens one slot every programmed period. The slot carries the oldest queued real request if there is one. If the queue is empty, the slot carries a dummy request to an address inside that tenant's own window. An observer of the port therefore sees fixed-size bursts at a constant rate, whatever the workload does. A tenant with shaping switched off has its requests forwarded as soon as the output register is free.

Every transaction is one incrementing burst of a fixed number of beats. Its address is aligned to the burst size, so a burst never crosses a DRAM row as long as the row size is a multiple of the burst size. Responses come back in order, one per accepted transaction. The responses to dummy reads are dropped inside the block. The `mem_dummy` flag travels with each request, so a write-channel instance can force the byte strobes of dummy writes to zero. One instance serves the read channel; a second instance serves the write channel. When several tenants want the port in the same cycle, the lowest tenant index wins.

Top module: `traffic_shaper`

## Requirements
- R1: Each tenant's queue holds up to QD requests (default 4). While the queue of the tenant named by `in_tid` is full, `in_ready` is 0.
- R2: The real requests of one tenant leave in the order they arrived. Each is issued with address bits [OFS-1:0] cleared, where OFS = log2(BURST_BYTES); the default burst is 64 bytes, so the low 6 bits are cleared.
- R3: Every transaction has `mem_len` = BEATS-1 (default 7). Its address is a multiple of BURST_BYTES.
- R4: While `mem_ready` stays high and no other tenant is competing, a shaped tenant's transactions are accepted exactly P cycles apart. P is the tenant's period field; any value below 2 acts as 2.
- R5: A shaped tenant's slot carries a real request (`mem_dummy` = 0) whenever that tenant's queue is not empty when the slot is staged. Otherwise the slot carries a dummy (`mem_dummy` = 1).
- R6: The dummy addresses of a tenant:
  - They start at the tenant's burst-aligned low bound.
  - They step by BURST_BYTES after each accepted dummy.
  - They return to the low bound when the next address would reach or pass the high bound, which is exclusive.
  - They restart at the low bound after shaping is switched off and on again.
- R7: Once `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr`, `mem_tid` and `mem_dummy` stay unchanged until the transaction is accepted. The tenant's timer restarts on acceptance, so the next slot comes P cycles after that acceptance.
- R8: For a tenant with shaping off, no dummy is ever issued. Its queued requests are forwarded unshaped. A request accepted at clock edge e shows on `mem_valid` after edge e+1 when the output register is free.
- R9: Each `rsp_in_valid` beat belongs to the oldest accepted transaction that has no response yet. It is forwarded on `rsp_valid` in the same cycle, with that transaction's tenant on `rsp_tid`, only if the transaction was real. Responses to dummies never show on `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shape_en | input | NT | Per-tenant shaping enable |
| cfg_period | input | NT*PW | Per-tenant slot period in cycles |
| cfg_lo | input | NT*AW | Per-tenant low bound of the dummy window (inclusive) |
| cfg_hi | input | NT*AW | Per-tenant high bound of the dummy window (exclusive) |
| in_valid | input | 1 | Request from the load engine is valid |
| in_ready | output | 1 | Queue of the addressed tenant can take the request |
| in_tid | input | TW | Tenant of the incoming request |
| in_addr | input | AW | Byte address of the incoming request |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory port accepts the request |
| mem_addr | output | AW | Burst-aligned request address |
| mem_tid | output | TW | Tenant of the request |
| mem_dummy | output | 1 | Request is a dummy |
| mem_len | output | LW | Burst length minus one |
| rsp_in_valid | input | 1 | Response beat from memory |
| rsp_in_data | input | DW | Response data from memory |
| rsp_valid | output | 1 | Response for a real request |
| rsp_tid | output | TW | Tenant of the forwarded response |
| rsp_data | output | DW | Forwarded response data |

## Verification
A request accepted at clock edge e goes into its tenant's queue. The earliest it can be staged in the output register is edge e+1, and it is visible on `mem_valid` from then on. The bench checks this two-edge latency once, on the falling edge after e+1.

A shaped slot is accepted P edges after the previous acceptance of the same tenant. The monitor timestamps every acceptance in the falling-edge half of the cycle. It checks the gap only between slots where the port never stalled, and only in phases where no second tenant competes.

Responses are combinational. The responder drives each beat one cycle after the acceptance it answers, so the tracking entry already exists, and `rsp_valid` is sampled part-way into that same cycle. Real requests are pushed right after a slot has just been taken, so the model's queue state cannot race the staging edge.

// File: rtl/traffic_shaper.sv
module traffic_shaper #(
  parameter int NT = 2,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int QD = 4,
  parameter int OUTS = 4,
  parameter int BURST_BYTES = 64,
  parameter int BEATS = 8,
  parameter int TW = (NT > 1) ? $clog2(NT) : 1,
  parameter int LW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    cfg_shape_en,
  input  logic [NT*PW-1:0] cfg_period,
  input  logic [NT*AW-1:0] cfg_lo,
  input  logic [NT*AW-1:0] cfg_hi,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TW-1:0]    in_tid,
  input  logic [AW-1:0]    in_addr,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [TW-1:0]    mem_tid,
  output logic             mem_dummy,
  output logic [LW-1:0]    mem_len,
  input  logic             rsp_in_valid,
  input  logic [DW-1:0]    rsp_in_data,
  output logic             rsp_valid,
  output logic [TW-1:0]    rsp_tid,
  output logic [DW-1:0]    rsp_data
);
  localparam int OFS = $clog2(BURST_BYTES);
  localparam int QIW = (QD > 1) ? $clog2(QD) : 1;
  localparam int QCW = $clog2(QD + 1);
  localparam int OIW = (OUTS > 1) ? $clog2(OUTS) : 1;
  localparam int OCW = $clog2(OUTS + 1);
  localparam logic [AW-1:0] BSTEP = AW'(BURST_BYTES);

  logic          out_valid, out_dummy;
  logic [AW-1:0] out_addr;
  logic [TW-1:0] out_tid;
  logic [NT-1:0] want, dsel, q_full, take;
  logic [AW-1:0] cand  [NT];
  logic [AW-1:0] lo_al [NT];
  logic [AW-1:0] hi_al [NT];
  logic          any, acc, load;
  logic [TW-1:0] g;

  logic [OCW-1:0] trk_cnt;
  logic [OIW-1:0] trk_rp, trk_wp;
  logic           trk_d [OUTS];
  logic [TW-1:0]  trk_t [OUTS];
  logic           trk_pop;

  assign mem_valid = out_valid && (trk_cnt != OCW'(OUTS));
  assign acc       = mem_valid && mem_ready;
  assign load      = !out_valid || acc;
  assign mem_addr  = out_addr;
  assign mem_tid   = out_tid;
  assign mem_dummy = out_dummy;
  assign mem_len   = LW'(BEATS - 1);
  assign in_ready  = !q_full[in_tid];

  genvar t;
  generate
    for (t = 0; t < NT; t++) begin : g_ten
      logic [AW-1:0]  qm [QD];
      logic [QIW-1:0] rp, wp;
      logic [QCW-1:0] qc;
      logic [PW-1:0]  tmr, per, per_raw;
      logic [AW-1:0]  ptr, nxt;
      logic           push, pop, staged, due, mine_acc;

      assign lo_al[t]  = {cfg_lo[t*AW+OFS +: AW-OFS], {OFS{1'b0}}};
      assign hi_al[t]  = {cfg_hi[t*AW+OFS +: AW-OFS], {OFS{1'b0}}};
      assign per_raw   = cfg_period[t*PW +: PW];
      assign per       = (per_raw < PW'(2)) ? PW'(2) : per_raw;
      assign staged    = out_valid && (out_tid == TW'(t));
      assign mine_acc  = acc && (out_tid == TW'(t));
      assign due       = cfg_shape_en[t] && !staged && (tmr >= per - PW'(2));
      assign want[t]   = cfg_shape_en[t] ? due : (qc != '0);
      assign dsel[t]   = (qc == '0);
      assign q_full[t] = (qc == QCW'(QD));
      assign cand[t]   = (qc != '0) ? qm[rp] :
                         ((ptr >= lo_al[t] && ptr < hi_al[t]) ? ptr : lo_al[t]);
      assign push      = in_valid && !q_full[t] && (in_tid == TW'(t));
      assign pop       = take[t] && (qc != '0);
      assign nxt       = out_addr + BSTEP;

      always_ff @(posedge clk)
        if (push) qm[wp] <= {in_addr[AW-1:OFS], {OFS{1'b0}}};

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rp  <= '0;
          wp  <= '0;
          qc  <= '0;
          tmr <= '0;
          ptr <= '0;
        end else begin
          if (push) wp <= (wp == QIW'(QD - 1)) ? '0 : wp + 1'b1;
          if (pop)  rp <= (rp == QIW'(QD - 1)) ? '0 : rp + 1'b1;
          qc <= qc + QCW'(push) - QCW'(pop);
          if (!cfg_shape_en[t])  tmr <= '0;
          else if (mine_acc)     tmr <= '0;
          else if (tmr != '1)    tmr <= tmr + 1'b1;
          if (!cfg_shape_en[t])            ptr <= lo_al[t];
          else if (mine_acc && out_dummy)  ptr <= (nxt >= hi_al[t]) ? lo_al[t] : nxt;
        end
      end

      AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        qc <= QCW'(QD)); // R1
    end
  endgenerate

  always_comb begin
    any = 1'b0;
    g   = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (want[i]) begin
        any = 1'b1;
        g   = TW'(i);
      end
  end

  assign take = (load && any) ? (NT'(1) << g) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dummy <= 1'b0;
      out_addr  <= '0;
      out_tid   <= '0;
    end else if (load) begin
      out_valid <= any;
      if (any) begin
        out_addr  <= cand[g];
        out_tid   <= g;
        out_dummy <= cfg_shape_en[g] && dsel[g];
      end
    end
  end

  assign trk_pop   = rsp_in_valid && (trk_cnt != '0);
  assign rsp_valid = trk_pop && !trk_d[trk_rp];
  assign rsp_tid   = trk_t[trk_rp];
  assign rsp_data  = rsp_in_data;

  always_ff @(posedge clk)
    if (acc) begin
      trk_d[trk_wp] <= out_dummy;
      trk_t[trk_wp] <= out_tid;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_cnt <= '0;
      trk_rp  <= '0;
      trk_wp  <= '0;
    end else begin
      if (acc)     trk_wp <= (trk_wp == OIW'(OUTS - 1)) ? '0 : trk_wp + 1'b1;
      if (trk_pop) trk_rp <= (trk_rp == OIW'(OUTS - 1)) ? '0 : trk_rp + 1'b1;
      trk_cnt <= trk_cnt + OCW'(acc) - OCW'(trk_pop);
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_tid) && $stable(mem_dummy)); // R7
  AST_BURST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[OFS-1:0] == '0 && mem_len == LW'(BEATS - 1)); // R3
  AST_DUMMY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_dummy && hi_al[mem_tid] > lo_al[mem_tid]
      |-> mem_addr >= lo_al[mem_tid] && mem_addr < hi_al[mem_tid]); // R6
  AST_RSP_HAS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_in_valid |-> trk_cnt != '0); // R9
  AST_NO_RSP_FOR_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(trk_cnt) != 0 && !trk_d[trk_rp]); // R9
endmodule

// File: tb/tb_traffic_shaper.sv
`timescale 1ns/100ps
module tb_traffic_shaper;
  localparam logic [31:0] LO0 = 32'h1000, HI0 = 32'h10C0;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [1:0]  cfg_shape_en;
  logic [15:0] per0, per1;
  logic        in_valid, in_ready, in_tid;
  logic [31:0] in_addr;
  logic        mem_valid, mem_ready, mem_dummy, rsp_in_valid, rsp_valid, rsp_tid, mem_tid;
  logic [31:0] mem_addr, rsp_in_data, rsp_data;
  logic [2:0]  mem_len;

  traffic_shaper dut (
    .clk(clk), .rst_n(rst_n), .cfg_shape_en(cfg_shape_en), .cfg_period({per1, per0}),
    .cfg_lo({32'h8000, LO0}), .cfg_hi({32'h9000, HI0}),
    .in_valid(in_valid), .in_ready(in_ready), .in_tid(in_tid), .in_addr(in_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_tid(mem_tid),
    .mem_dummy(mem_dummy), .mem_len(mem_len), .rsp_in_valid(rsp_in_valid),
    .rsp_in_data(rsp_in_data), .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_data(rsp_data));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_acc = 0, n_dummy = 0, n_real_exp = 0, n_real_rsp = 0;
  logic [31:0] rq0[$], rq1[$];
  logic [33:0] pend[$];
  logic [31:0] mptr;
  bit en0_m = 0, chk_gap = 0, have_last = 0, stalled = 0, wrap_seen = 0, mon_on = 0;
  int last_acc = 0;
  event ev_t0;

  task automatic chk(input bit ok, input string req, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic int per_eff();
    return (per0 < 2) ? 2 : int'(per0);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor, scoreboard and responder
  initial begin
    logic pv = 0, pd = 0, pt = 0;
    logic [31:0] pa = 0;
    logic [33:0] cur, e;
    bit drv;
    forever begin
      @(negedge clk);
      #1;
      if (mon_on) begin
        if (pv) chk(mem_valid && mem_addr == pa && mem_tid == pt && mem_dummy == pd, "R7",
          $sformatf("stalled request changed: addr %h tid %0d dummy %0d, expected %h %0d %0d",
                    mem_addr, mem_tid, mem_dummy, pa, pt, pd));
        drv = (pend.size() > 0);
        rsp_in_valid = drv;
        if (drv) begin
          cur = pend.pop_front();
          rsp_in_data = cur[31:0];
        end
        if (mem_valid && mem_ready) begin
          n_acc++;
          chk(mem_len == 3'd7 && mem_addr[5:0] == 6'd0, "R3",
              $sformatf("len %0d addr %h, expected 7 and 64-byte aligned", mem_len, mem_addr));
          if (mem_tid == 1'b1) begin
            chk(!mem_dummy && rq1.size() > 0 && mem_addr == rq1[0], "R8",
                $sformatf("tenant 1 got addr %h dummy %0d, expected %h real", mem_addr, mem_dummy,
                          (rq1.size() > 0) ? rq1[0] : 32'hx));
            if (rq1.size() > 0) void'(rq1.pop_front());
          end else begin
            if (en0_m && rq0.size() == 0) begin
              chk(mem_dummy && mem_addr == mptr, "R6",
                  $sformatf("dummy got addr %h dummy %0d, expected %h dummy 1", mem_addr, mem_dummy, mptr));
              if (mptr == HI0 - 32'h40 && mem_dummy) wrap_seen = 1;
              mptr = (mptr + 32'h40 >= HI0) ? LO0 : mptr + 32'h40;
            end else begin
              chk(!mem_dummy && rq0.size() > 0 && mem_addr == rq0[0], "R5",
                  $sformatf("tenant 0 got addr %h dummy %0d, expected %h real", mem_addr, mem_dummy,
                            (rq0.size() > 0) ? rq0[0] : 32'hx));
              if (rq0.size() > 0) void'(rq0.pop_front());
            end
            if (en0_m && chk_gap && have_last && !stalled)
              chk(cyc - last_acc == per_eff(), "R4",
                  $sformatf("slot gap %0d, expected %0d", cyc - last_acc, per_eff()));
            last_acc = cyc;
            have_last = 1;
            stalled = 0;
            -> ev_t0;
          end
          if (mem_dummy) n_dummy++;
          else n_real_exp++;
          e = {mem_dummy, mem_tid, 32'(n_acc)};
          pend.push_back(e);
        end
        if (mem_valid && !mem_ready) stalled = 1;
        pv = mem_valid && !mem_ready;
        pa = mem_addr;
        pt = mem_tid;
        pd = mem_dummy;
        #0.5;
        if (drv) begin
          if (cur[33]) chk(!rsp_valid, "R9", $sformatf("dummy response leaked: rsp_valid %0d, expected 0", rsp_valid));
          else begin
            chk(rsp_valid && rsp_tid == cur[32] && rsp_data == cur[31:0], "R9",
                $sformatf("rsp valid %0d tid %0d data %0d, expected 1 %0d %0d",
                          rsp_valid, rsp_tid, rsp_data, cur[32], cur[31:0]));
            if (rsp_valid) n_real_rsp++;
          end
        end else chk(!rsp_valid, "R9", $sformatf("rsp_valid %0d without a beat, expected 0", rsp_valid));
      end
    end
  end

  task automatic send_req(input logic tid, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1;
    in_tid = tid;
    in_addr = a;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (tid) rq1.push_back({a[31:6], 6'd0});
    else rq0.push_back({a[31:6], 6'd0});
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    int base_acc, base_dum;
    rst_n = 0; cfg_shape_en = 0; per0 = 10; per1 = 10;
    in_valid = 0; in_tid = 0; in_addr = 0; mem_ready = 1;
    rsp_in_valid = 0; rsp_in_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!mem_valid && in_ready && !rsp_valid, "R1",
        $sformatf("after reset valid %0d ready %0d rsp %0d, expected 0 1 0", mem_valid, in_ready, rsp_valid));
    mon_on = 1;

    // R8 passthrough with shaping off, latency of two edges
    send_req(1, 32'h2004);
    idle();
    @(negedge clk);
    #1.2;
    chk(mem_tid == 1'b1 && !mem_dummy && mem_addr == 32'h2000, "R8",
        $sformatf("latency: tid %0d addr %h, expected 1 00002000", mem_tid, mem_addr));
    send_req(1, 32'h2048);
    send_req(1, 32'h20C0);
    idle();
    wait_cyc(20);
    chk(n_dummy == 0, "R8", $sformatf("dummies with shaping off %0d, expected 0", n_dummy));

    // R4 R5 R6 idle tenant emits dummies at a fixed rate and wraps
    mptr = LO0; have_last = 0; chk_gap = 1;
    @(negedge clk);
    cfg_shape_en[0] = 1; en0_m = 1;
    base_dum = n_dummy;
    wait_cyc(65);
    chk(n_dummy - base_dum >= 5, "R5", $sformatf("dummies %0d, expected at least 5", n_dummy - base_dum));
    chk(wrap_seen, "R6", $sformatf("wrap seen %0d, expected 1", wrap_seen));

    // R5 a queued real request takes the next slot
    @(ev_t0);
    send_req(0, 32'h5010);
    idle();
    wait_cyc(30);

    // R1 back-pressure, R2 order
    @(ev_t0);
    send_req(0, 32'h7000);
    send_req(0, 32'h7040);
    send_req(0, 32'h7080);
    send_req(0, 32'h70C0);
    @(negedge clk);
    in_valid = 1; in_tid = 0; in_addr = 32'h7100;
    #1;
    chk(!in_ready, "R1", $sformatf("in_ready %0d with full queue, expected 0", in_ready));
    send_req(0, 32'h7100);
    idle();
    wait_cyc(60);
    chk(rq0.size() == 0, "R2", $sformatf("queued reals left %0d, expected 0", rq0.size()));

    // R7 stall holds the slot, timer restarts on acceptance
    @(ev_t0);
    @(negedge clk);
    mem_ready = 0;
    base_acc = n_acc;
    wait_cyc(30);
    chk(n_acc == base_acc && mem_valid, "R7",
        $sformatf("accepts during stall %0d valid %0d, expected 0 1", n_acc - base_acc, mem_valid));
    mem_ready = 1;
    wait_cyc(35);

    // R4 R6 small period acts as 2, pointer restarts after re-enable
    @(ev_t0);
    @(negedge clk);
    cfg_shape_en[0] = 0; en0_m = 0;
    wait_cyc(3);
    per0 = 1; mptr = LO0; have_last = 0;
    cfg_shape_en[0] = 1; en0_m = 1;
    wait_cyc(20);
    @(ev_t0);
    @(negedge clk);
    per0 = 10; have_last = 0;
    @(ev_t0);
    @(negedge clk);
    cfg_shape_en[0] = 0; en0_m = 0;

    // R8 tenant 0 unshaped: no dummies, real forwarded
    wait_cyc(5);
    send_req(0, 32'h6020);
    idle();
    wait_cyc(10);
    base_acc = n_acc;
    wait_cyc(30);
    chk(n_acc == base_acc, "R8", $sformatf("transactions while idle %0d, expected 0", n_acc - base_acc));
    chk(rq0.size() == 0 && rq1.size() == 0, "R2",
        $sformatf("unsent reals %0d/%0d, expected 0/0", rq0.size(), rq1.size()));
    wait_cyc(5);
    chk(pend.size() == 0 && n_real_rsp == n_real_exp, "R9",
        $sformatf("real responses %0d, expected %0d", n_real_rsp, n_real_exp));
    finish_run();
  end
endmodule